// File: doc/BRIEF.md
# Microcontroller Firmware Download Port

This block lets a host load a program image into the byte-wide program RAM of an embedded microcontroller and sweep it back out for checking. The host talks to it through a single 32-bit control word: writes carry a command code in the top byte together with a data byte and a byte address, and reads return a status word built from the current command code and the stored data.

A load runs in three phases. The host first writes the upload code, which holds the core in reset and stores one byte per write. It then reads the image back. Each read returns the byte at an internal pointer together with that pointer's value, then steps the pointer, so the whole image can be compared in one pass. If the high address bits in a read-back differ from those written, the host knows that retrying at the same address cannot fix the error.

Completion takes two writes. The finish code records the image length while the core is still held. The release code, which is accepted only after the finish code, lets the core run. A second read port gives the core's instruction fetch access to the RAM.

Top module: `fwdl_port`

## Requirements
- R1: After reset the command code is 0x00, `core_hold` is 1 and `rd_data` is 0.
- R2: A write with top byte 0x0F enters upload mode and stores `wr_data[23:16]` at address `wr_data[ADDR_W-1:0]`. It also loads the read pointer with that address. Bits 15:ADDR_W of the word are ignored.
- R3: In upload mode, a read returns `{8'h0F, byte at pointer, 2'b00, pointer zero-extended to 14 bits}` in `rd_data` on the cycle after `rd_en`. The read then increments the pointer, which wraps from 2**ADDR_W-1 to 0.
- R4: A read issued right after an upload write returns exactly the byte and address just written.
- R5: A write with top byte 0x03 records `wr_data[15:0]` as the image length and keeps the core held. Reads in this state return `{8'h03, 8'h00, length}` and do not move the pointer.
- R6: A write with top byte 0x13 made while the code is 0x03 or 0x13 is accepted. It records the length, and `core_hold` drops on the cycle after. Reads then return `{8'h13, 8'h00, length}`.
- R7: A write with top byte 0x13 made while the code is anything other than 0x03 or 0x13 is ignored. The code, pointer and `core_hold` are unchanged.
- R8: `core_hold` is 1 whenever the code is not 0x13. A write of any other top byte is stored as the code and re-asserts the hold. For codes other than 0x0F, 0x03 and 0x13, reads return `{code, 24'h0}`.
- R9: When `wr_en` and `rd_en` are high in the same cycle, the write is performed and the read is dropped: `rd_data` and the pointer are unchanged.
- R10: `fetch_data` returns the RAM byte at `fetch_addr` one cycle after the address is applied.
- R11: `rd_data` holds its value in cycles without an accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word: code [31:24], byte [23:16], address/length [15:0] |
| rd_en | input | 1 | Control word read strobe |
| rd_data | output | 32 | Registered read-back word |
| core_hold | output | 1 | Reset to the microcontroller core, active high |
| fetch_addr | input | ADDR_W | Core fetch address |
| fetch_data | output | 8 | Core fetch data, one cycle latency |

## Verification
The assertions check the following on every cycle:
- the hold drops only after an accepted release write, and an early release changes nothing;
- any non-release write restores the hold;
- each upload-mode read steps the pointer and reports the old pointer;
- a read right after an upload write returns that write's byte and address;
- `rd_data` stays frozen without an accepted read or when a write collides with a read.

Only the bench scenarios can show the stored contents across a full sweep, the wrap of the pointer at the top address, the ignored high address bits, the length reported in the finish and run states, and the fetch port returning bytes written earlier.

// File: rtl/fwdl_pkg.sv
package fwdl_pkg;

    localparam logic [7:0] CODE_IDLE   = 8'h00;
    localparam logic [7:0] CODE_UPLOAD = 8'h0F;
    localparam logic [7:0] CODE_FINISH = 8'h03;
    localparam logic [7:0] CODE_RUN    = 8'h13;

    localparam int FIELD_W = 14;
    localparam int ARG_W   = 16;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_STORE,
        OP_FINISH,
        OP_RELEASE,
        OP_SETCODE
    } op_e;

    typedef struct packed {
        op_e              op;
        logic [7:0]       code;
        logic [7:0]       data;
        logic [ARG_W-1:0] arg;
    } cmd_t;

    function automatic cmd_t decode_word(input logic [31:0] w, input logic [7:0] cur);
        cmd_t c;
        c.code = w[31:24];
        c.data = w[23:16];
        c.arg  = w[15:0];
        case (w[31:24])
            CODE_UPLOAD: c.op = OP_STORE;
            CODE_FINISH: c.op = OP_FINISH;
            CODE_RUN:    c.op = (cur == CODE_FINISH || cur == CODE_RUN) ? OP_RELEASE : OP_NONE;
            default:     c.op = OP_SETCODE;
        endcase
        return c;
    endfunction

    function automatic logic [31:0] make_readback(input logic [7:0] code,
                                                  input logic [7:0] b,
                                                  input logic [FIELD_W-1:0] a,
                                                  input logic [ARG_W-1:0] len);
        logic [31:0] r;
        if (code == CODE_UPLOAD)
            r = {code, b, 2'b00, a};
        else if (code == CODE_FINISH || code == CODE_RUN)
            r = {code, 8'h00, len};
        else
            r = {code, 24'h0};
        return r;
    endfunction

endpackage

// File: rtl/fwdl_decode.sv
module fwdl_decode
    import fwdl_pkg::*;
(
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic [7:0]  cur_code,
    output cmd_t        cmd
);
    always_comb begin
        cmd = decode_word(wr_data, cur_code);
        if (!wr_en) cmd.op = OP_NONE;
    end
endmodule

// File: rtl/fwdl_ram.sv
module fwdl_ram #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] host_addr,
    output logic [DW-1:0] host_q,
    input  logic [AW-1:0] fetch_addr,
    output logic [DW-1:0] fetch_q
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        fetch_q <= mem[fetch_addr];
    end

    assign host_q = mem[host_addr];
endmodule

// File: rtl/fwdl_ctrl.sv
module fwdl_ctrl
    import fwdl_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  cmd_t          cmd,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [7:0]    host_byte,
    output logic [7:0]    code_q,
    output logic [AW-1:0] ptr_q,
    output logic [31:0]   rd_data,
    output logic          ram_we,
    output logic [AW-1:0] ram_waddr,
    output logic [7:0]    ram_wdata
);
    logic [ARG_W-1:0]   len_q;
    logic [FIELD_W-1:0] ptr_ext;
    logic               rd_go;

    generate
        if (AW < FIELD_W) begin : g_pad
            assign ptr_ext = {{(FIELD_W-AW){1'b0}}, ptr_q};
        end else begin : g_full
            assign ptr_ext = ptr_q[FIELD_W-1:0];
        end
    endgenerate

    assign ram_we    = (cmd.op == OP_STORE);
    assign ram_waddr = cmd.arg[AW-1:0];
    assign ram_wdata = cmd.data;
    assign rd_go     = rd_en && !wr_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q  <= CODE_IDLE;
            ptr_q   <= '0;
            len_q   <= '0;
            rd_data <= '0;
        end else begin
            case (cmd.op)
                OP_STORE: begin
                    code_q <= CODE_UPLOAD;
                    ptr_q  <= cmd.arg[AW-1:0];
                end
                OP_FINISH: begin
                    code_q <= CODE_FINISH;
                    len_q  <= cmd.arg;
                end
                OP_RELEASE: begin
                    code_q <= CODE_RUN;
                    len_q  <= cmd.arg;
                end
                OP_SETCODE: code_q <= cmd.code;
                default: ;
            endcase
            if (rd_go) begin
                rd_data <= make_readback(code_q, host_byte, ptr_ext, len_q);
                if (code_q == CODE_UPLOAD) ptr_q <= ptr_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/fwdl_port.sv
module fwdl_port
    import fwdl_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    input  logic              rd_en,
    output logic [31:0]       rd_data,
    output logic              core_hold,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic [7:0]        fetch_data
);
    cmd_t              cmd;
    logic [7:0]        code_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [7:0]        host_byte;
    logic              ram_we;
    logic [ADDR_W-1:0] ram_waddr;
    logic [7:0]        ram_wdata;

    fwdl_decode u_dec (
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .cur_code (code_q),
        .cmd      (cmd)
    );

    fwdl_ctrl #(.AW(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .host_byte (host_byte),
        .code_q    (code_q),
        .ptr_q     (ptr_q),
        .rd_data   (rd_data),
        .ram_we    (ram_we),
        .ram_waddr (ram_waddr),
        .ram_wdata (ram_wdata)
    );

    fwdl_ram #(.AW(ADDR_W), .DW(8)) u_ram (
        .clk        (clk),
        .we         (ram_we),
        .waddr      (ram_waddr),
        .wdata      (ram_wdata),
        .host_addr  (ptr_q),
        .host_q     (host_byte),
        .fetch_addr (fetch_addr),
        .fetch_q    (fetch_data)
    );

    assign core_hold = (code_q != CODE_RUN);
endmodule

// File: rtl/fwdl_port_chk.sv
module fwdl_port_chk #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [7:0]        wr_top,
    input logic [7:0]        wr_byte,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              rd_en,
    input logic [31:0]       rd_data,
    input logic              core_hold,
    input logic [7:0]        code_q,
    input logic [ADDR_W-1:0] ptr_q
);
    // R6
    release_src_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(core_hold) |-> $past(wr_en && wr_top == 8'h13 &&
                                   (code_q == 8'h03 || code_q == 8'h13)));

    // R7
    early_release_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_top == 8'h13 && code_q != 8'h03 && code_q != 8'h13)
        |=> $stable(code_q) && core_hold);

    // R8
    rehold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_top != 8'h13) |=> core_hold);

    // R3
    ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && code_q == 8'h0F)
        |=> ptr_q == ADDR_W'($past(ptr_q) + 1'b1) && rd_data[ADDR_W-1:0] == $past(ptr_q));

    // R4
    read_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_top == 8'h0F) ##1 (rd_en && !wr_en)
        |=> rd_data[23:16] == $past(wr_byte, 2) && rd_data[ADDR_W-1:0] == $past(wr_addr, 2));

    // R9
    write_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_en) |=> $stable(rd_data));

    // R11
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));
endmodule

bind fwdl_port fwdl_port_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_top    (wr_data[31:24]),
    .wr_byte   (wr_data[23:16]),
    .wr_addr   (wr_data[ADDR_W-1:0]),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .core_hold (core_hold),
    .code_q    (code_q),
    .ptr_q     (ptr_q)
);

// File: tb/test_fwdl_port.sv
module test_fwdl_port;
    localparam int AW    = 11;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [31:0]   wr_data = '0;
    logic          rd_en = 1'b0;
    logic [31:0]   rd_data;
    logic          core_hold;
    logic [AW-1:0] fetch_addr = '0;
    logic [7:0]    fetch_data;

    always #10 clk = ~clk;

    fwdl_port #(.ADDR_W(AW)) i_fwdl_port (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .core_hold(core_hold),
        .fetch_addr(fetch_addr), .fetch_data(fetch_data)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [7:0] mdl [DEPTH];
    logic [31:0] exp_q [$];
    string tag_q [$];
    logic rd_issued = 1'b0;

    // monitor: an accepted read updates rd_data at the edge; compare at the next negedge
    always @(posedge clk) rd_issued <= rd_en && !wr_en && !rst;

    always @(negedge clk) begin
        logic [31:0] e;
        string t;
        if (rd_issued) begin
            n_vec++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL unexpected read: actual=%h expected=none", rd_data);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rd_data !== e) begin
                    n_bad++;
                    $display("FAIL %s read-back: actual=%h expected=%h", t, rd_data, e);
                end
            end
        end
    end

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", r, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] w);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = w;
        if (w[31:24] == 8'h0F) mdl[w[AW-1:0]] = w[23:16];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [31:0] e, input string t);
        @(negedge clk);
        rd_en = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    function automatic logic [31:0] up_word(input int a);
        return {8'h0F, mdl[a], 2'b00, 14'(a)};
    endfunction

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] prev;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 core_hold", {31'b0, core_hold}, 32'd1);
        chk("R1 rd_data", rd_data, 32'h0);

        // R2 enter upload, R8 core still held
        wr(32'h0F00_0000);
        chk("R8 hold in upload", {31'b0, core_hold}, 32'd1);

        // R4 write then read back each byte
        for (int i = 0; i < 8; i++) begin
            wr({8'h0F, 8'(i * 37 + 5), 16'(i)});
            rd(up_word(i), "R4");
        end

        // R2 bits above the implemented address are ignored
        wr({8'h0F, 8'hA5, 2'b11, 14'h3805});
        rd(up_word(5), "R2");

        // R3 full sweep of the first bytes with auto increment
        wr({8'h0F, mdl[0], 16'h0000});
        for (int i = 0; i < 8; i++) rd(up_word(i), "R3");

        // R3 wrap from the top address to zero
        wr({8'h0F, 8'h5C, 16'(DEPTH - 1)});
        rd(up_word(DEPTH - 1), "R3");
        rd(up_word(0), "R3");

        // R9 write wins over a same-cycle read
        wr({8'h0F, mdl[3], 16'd3});
        prev = rd_data;
        @(negedge clk);
        wr_en = 1'b1;
        rd_en = 1'b1;
        wr_data = {8'h0F, 8'h77, 16'd6};
        mdl[6] = 8'h77;
        @(negedge clk);
        wr_en = 1'b0;
        rd_en = 1'b0;
        chk("R9 rd_data unchanged", rd_data, prev);
        rd(up_word(6), "R9");

        // R10 fetch port
        @(negedge clk);
        fetch_addr = AW'(DEPTH - 1);
        @(negedge clk);
        chk("R10 fetch top", {24'h0, fetch_data}, 32'h5C);
        fetch_addr = AW'(6);
        @(negedge clk);
        chk("R10 fetch 6", {24'h0, fetch_data}, 32'h77);

        // R7 release before finish is ignored
        wr(32'h1300_0010);
        chk("R7 core_hold", {31'b0, core_hold}, 32'd1);
        rd(up_word(7), "R7");

        // R5 finish records length, keeps hold, no pointer motion
        wr(32'h0300_0800);
        chk("R5 core_hold", {31'b0, core_hold}, 32'd1);
        rd(32'h0300_0800, "R5");
        rd(32'h0300_0800, "R5");
        // R11 rd_data holds while idle
        repeat (4) @(negedge clk);
        chk("R11 rd_data hold", rd_data, 32'h0300_0800);

        // R6 release accepted after finish
        wr(32'h1300_0800);
        chk("R6 core_hold", {31'b0, core_hold}, 32'd0);
        rd(32'h1300_0800, "R6");

        // R8 other code re-holds the core
        wr(32'h0500_0000);
        chk("R8 core_hold", {31'b0, core_hold}, 32'd1);
        rd(32'h0500_0000, "R8");
        wr(32'h1300_0000);
        chk("R7 ignored from other code", {31'b0, core_hold}, 32'd1);
        rd(32'h0500_0000, "R7");

        // R6 release again through finish
        wr(32'h0300_0123);
        wr(32'h1300_0456);
        chk("R6 second release", {31'b0, core_hold}, 32'd0);
        rd(32'h1300_0456, "R6");
        @(negedge clk);
        fetch_addr = AW'(5);
        @(negedge clk);
        chk("R10 fetch while running", {24'h0, fetch_data}, 32'hA5);

        repeat (2) @(negedge clk);
        chk("R3 queue drained", 32'(exp_q.size()), 32'd0);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule